// File: doc/BRIEF.md
# Auto-Reload PWM Timer

This block is a 12-bit up-counter that drives a single pulse-width-modulated output. When the counter reaches its all-ones value it does not return to zero. It restarts from a programmable reload value, so software sets the period by choosing where the count begins. The count advances on every system clock, on each pulse of an external slow timebase tick, or not at all, as picked by a two-bit field.

The duty cycle and the reload value are each written into a preload register. Both take effect only when the counter wraps, so a period in progress is never cut short or stretched. The duty-cycle value is written in two parts: first the upper bits, then the low byte, and the low-byte write commits both. The output can be inverted, and it can be released from the pin. Wrap and compare events set sticky flags. Each flag can raise its own interrupt line, and reading the status register clears the flags.

Top module: `reload_pwm_timer`

## Requirements
- R1: While counting is enabled, each enabled step raises the count by one. A step taken at count 0xFFF loads the reload preload value into the counter instead. The count reads back at address 6 (low byte) and address 7 (bits 3:0 of the byte hold count bits 11:8).
- R2: A wrap step sets the wrap flag, which is bit 4 of address 0. The wrap interrupt line equals that flag ANDed with the wrap enable, which is bit 0 of address 0.
- R3: A write to address 3 stages bits 3:0 as duty bits 11:8 and leaves the preload readback unchanged. A later write to address 4 commits the staged bits together with the low byte, and addresses 3 and 4 then read back the new preload. The active duty value takes the preload only on a wrap step.
- R4: An enabled step taken while the count equals the active duty value sets the compare flag, which is bit 5 of address 0. The compare interrupt line equals that flag ANDed with the compare enable, which is bit 1 of address 0.
- R5: The uninverted waveform is high while the count is below the active duty value and low otherwise. Bit 1 of address 5 inverts it.
- R6: Bit 0 of address 5 is the output enable. When it is clear, the pin-drive signal is 0 and the output is held at 0.
- R7: Bits 3:2 of address 0 select the step source. 01 steps on every clock. 10 steps on each clock where the slow tick is high. 00 and 11 hold the count.
- R8: A read of address 0 returns the flags as they were before the read, then clears them. A flag event in the same cycle as the read wins, and that flag stays set.
- R9: After reset, every register, flag, the count, the active duty value and both interrupt lines are 0, and the output is not driven.
- R10: The reload preload is written through address 1 (low byte) and address 2 (bits 3:0 hold value bits 11:8). It changes the count only at the next wrap, which loads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_slow | input | 1 | Slow timebase pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by addr |
| pwm_out | output | 1 | Waveform output |
| pwm_oe | output | 1 | Pin drive enable |
| irq_ovf | output | 1 | Wrap interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
Two events can land on the same clock edge: a wrap step that sets the wrap flag, and a status read that clears it. To force this, the bench parks the counter at 0xFFF in slow-tick mode. It then raises the slow tick and the status read strobe in the same cycle. The bench checks three things: the data returned by that read still shows the flag clear, the next status read shows the flag set, and the counter holds the reload value that was written while the counter was stopped.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT    = 3'd0;
  localparam logic [ADDR_W-1:0] A_RLD_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DUTY_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_DUTY_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_PWM     = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd7;

  typedef enum logic [1:0] {
    CK_OFF  = 2'b00,
    CK_SYS  = 2'b01,
    CK_SLOW = 2'b10,
    CK_HALT = 2'b11
  } clk_sel_t;

  // Step qualifier: which clock edges advance the counter
  function automatic logic step_enable(clk_sel_t sel, logic tick);
    case (sel)
      CK_SYS:  return 1'b1;
      CK_SLOW: return tick;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rpt_regs.sv
module rpt_regs
  import rpt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_evt,
  input  logic              cmp_evt,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdata,
  output logic              ovf_ie,
  output logic              cmp_ie,
  output clk_sel_t          clk_sel,
  output logic              oe,
  output logic              pol,
  output logic [CNT_W-1:0]  reload_pre,
  output logic [CNT_W-1:0]  duty_pre,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              stat_rd
);

  localparam int HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0] duty_stage;
  logic            wr_hit;

  // Upper part of a wide value, zero-extended to one data byte
  function automatic logic [DATA_W-1:0] hi_byte(logic [CNT_W-1:0] v);
    return DATA_W'(v[CNT_W-1:DATA_W]);
  endfunction

  // Sticky flag: a set in the same cycle beats the clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  assign wr_hit  = wr_en;
  assign stat_rd = rd_en && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_ie     <= 1'b0;
      cmp_ie     <= 1'b0;
      clk_sel    <= CK_OFF;
      oe         <= 1'b0;
      pol        <= 1'b0;
      reload_pre <= '0;
      duty_pre   <= '0;
      duty_stage <= '0;
    end else if (wr_hit) begin
      case (addr)
        A_STAT: begin
          ovf_ie  <= wdata[0];
          cmp_ie  <= wdata[1];
          clk_sel <= clk_sel_t'(wdata[3:2]);
        end
        A_RLD_LO:  reload_pre[DATA_W-1:0]     <= wdata;
        A_RLD_HI:  reload_pre[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        A_DUTY_HI: duty_stage                 <= wdata[HI_W-1:0];
        A_DUTY_LO: duty_pre                   <= {duty_stage, wdata};
        A_PWM: begin
          oe  <= wdata[0];
          pol <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= flag_next(ovf_flag, ovf_evt, stat_rd);
      cmp_flag <= flag_next(cmp_flag, cmp_evt, stat_rd);
    end
  end

  always_comb begin
    case (addr)
      A_STAT:    rdata = DATA_W'({cmp_flag, ovf_flag, clk_sel, cmp_ie, ovf_ie});
      A_RLD_LO:  rdata = reload_pre[DATA_W-1:0];
      A_RLD_HI:  rdata = hi_byte(reload_pre);
      A_DUTY_HI: rdata = hi_byte(duty_pre);
      A_DUTY_LO: rdata = duty_pre[DATA_W-1:0];
      A_PWM:     rdata = DATA_W'({pol, oe});
      A_CNT_LO:  rdata = cnt[DATA_W-1:0];
      A_CNT_HI:  rdata = hi_byte(cnt);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/rpt_counter.sv
module rpt_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [CNT_W-1:0] reload_pre,
  input  logic [CNT_W-1:0] duty_pre,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] duty_sh,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic at_top(logic [CNT_W-1:0] v);
    return v == CNT_MAX;
  endfunction

  function automatic logic [CNT_W-1:0] advance(logic [CNT_W-1:0] v,
                                               logic [CNT_W-1:0] rld);
    return at_top(v) ? rld : v + 1'b1;
  endfunction

  assign ovf_evt = step_en && at_top(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      duty_sh <= '0;
    end else begin
      if (step_en) cnt <= advance(cnt, reload_pre);
      if (ovf_evt) duty_sh <= duty_pre;
    end
  end

endmodule

// File: rtl/rpt_channel.sv
module rpt_channel #(
  parameter int CNT_W = 12
) (
  input  logic             step_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_sh,
  input  logic             oe,
  input  logic             pol,
  output logic             cmp_evt,
  output logic             pwm_out,
  output logic             pwm_oe
);

  // Uninverted level: high from reload until the count reaches the duty value
  function automatic logic raw_level(logic [CNT_W-1:0] c, logic [CNT_W-1:0] d);
    return c < d;
  endfunction

  logic level;

  assign cmp_evt = step_en && (cnt == duty_sh);
  assign level   = raw_level(cnt, duty_sh) ^ pol;
  assign pwm_oe  = oe;
  assign pwm_out = oe & level;

endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import rpt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic              irq_ovf,
  output logic              irq_cmp
);

  clk_sel_t         clk_sel;
  logic             step_en;
  logic             ovf_evt;
  logic             cmp_evt;
  logic             ovf_ie;
  logic             cmp_ie;
  logic             ovf_flag;
  logic             cmp_flag;
  logic             stat_rd;
  logic             oe;
  logic             pol;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_sh;
  logic [CNT_W-1:0] reload_pre;
  logic [CNT_W-1:0] duty_pre;

  assign step_en = step_enable(clk_sel, tick_slow);
  assign irq_ovf = ovf_flag & ovf_ie;
  assign irq_cmp = cmp_flag & cmp_ie;

  rpt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .cnt(cnt),
    .rdata(rdata), .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .clk_sel(clk_sel),
    .oe(oe), .pol(pol), .reload_pre(reload_pre), .duty_pre(duty_pre),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .stat_rd(stat_rd)
  );

  rpt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .reload_pre(reload_pre),
    .duty_pre(duty_pre), .cnt(cnt), .duty_sh(duty_sh), .ovf_evt(ovf_evt)
  );

  rpt_channel #(.CNT_W(CNT_W)) u_channel (
    .step_en(step_en), .cnt(cnt), .duty_sh(duty_sh), .oe(oe), .pol(pol),
    .cmp_evt(cmp_evt), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             ovf_evt,
  input logic             cmp_evt,
  input logic             stat_rd,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] duty_sh,
  input logic [CNT_W-1:0] reload_pre,
  input logic             pwm_out,
  input logic             pwm_oe
);

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ovf_evt) |=> (cnt == $past(cnt) + 1'b1));

  p_wrap_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == $past(reload_pre)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt));

  p_ovf_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  p_cmp_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_flag);

  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovf_evt) |=> !ovf_flag);

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_evt |=> $stable(duty_sh));

  p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe |-> !pwm_out);

endmodule

bind reload_pwm_timer rpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .ovf_evt(ovf_evt),
  .cmp_evt(cmp_evt), .stat_rd(stat_rd), .ovf_flag(ovf_flag),
  .cmp_flag(cmp_flag), .cnt(cnt), .duty_sh(duty_sh),
  .reload_pre(reload_pre), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/reload_pwm_timer_test.sv
`timescale 1ns/1ps
module reload_pwm_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_slow = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm_out, pwm_oe, irq_ovf, irq_cmp;

  int checks = 0;
  int errors = 0;
  logic [7:0] ctrl_v = 8'h00;

  always #2.5 clk = ~clk;

  reload_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_count(output int c);
    logic [7:0] lo, hi;
    rd(3'd6, lo);
    rd(3'd7, hi);
    c = {hi[3:0], lo};
  endtask

  // Exactly n system-clock steps
  task automatic steps(input int n);
    wr(3'd0, (ctrl_v & 8'hF3) | 8'h04);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, ctrl_v & 8'hF3);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R9 reg %0d after reset", a), d, 0);
    end
    chk("R9 pwm_oe after reset", pwm_oe, 0);
    chk("R9 irq lines after reset", {irq_ovf, irq_cmp}, 0);
  endtask

  task automatic t_step_sources;
    int c;
    steps(100);
    read_count(c);
    chk("R1 count after 100 system steps", c, 100);
    wr(3'd0, ctrl_v | 8'h0C);
    repeat (20) @(negedge clk);
    wr(3'd0, ctrl_v);
    read_count(c);
    chk("R7 select 11 holds count", c, 100);
    wr(3'd0, ctrl_v | 8'h08);
    repeat (7) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      tick_slow = 1'b1;
      @(negedge clk);
      tick_slow = 1'b0;
      @(negedge clk);
    end
    wr(3'd0, ctrl_v);
    read_count(c);
    chk("R7 slow tick steps", c, 105);
  endtask

  task automatic t_wrap;
    int c;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h0F);
    ctrl_v = 8'h01;
    wr(3'd0, ctrl_v);
    rd(3'd0, d);
    steps(4095 - 105);
    read_count(c);
    chk("R10 preload not applied before wrap", c, 12'hFFF);
    chk("R2 no wrap irq before wrap", irq_ovf, 0);
    steps(1);
    read_count(c);
    chk("R1 wrap loads reload value", c, 12'hF00);
    chk("R2 wrap irq raised", irq_ovf, 1);
    rd(3'd0, d);
    chk("R2 wrap flag bit 4", d[4], 1);
    chk("R8 read clears wrap irq", irq_ovf, 0);
    rd(3'd0, d);
    chk("R8 flags clear after read", d[5:4], 0);
  endtask

  task automatic t_duty;
    int c;
    logic [7:0] d;
    wr(3'd3, 8'h0F);
    rd(3'd3, d);
    chk("R3 high write alone not committed", d, 0);
    wr(3'd4, 8'h80);
    rd(3'd3, d);
    chk("R3 duty high readback", d, 8'h0F);
    rd(3'd4, d);
    chk("R3 duty low readback", d, 8'h80);
    wr(3'd5, 8'h01);
    chk("R3 old duty still active", pwm_out, 0);
    ctrl_v = 8'h03;
    wr(3'd0, ctrl_v);
    rd(3'd0, d);
    steps(255);
    chk("R3 no change before wrap", pwm_out, 0);
    steps(1);
    chk("R5 high below duty after wrap", pwm_out, 1);
    steps(128);
    chk("R5 low at duty value", pwm_out, 0);
    chk("R4 no compare irq yet", irq_cmp, 0);
    steps(1);
    chk("R4 compare irq after step at match", irq_cmp, 1);
    read_count(c);
    chk("R1 count after compare", c, 12'hF81);
    wr(3'd5, 8'h03);
    chk("R5 polarity inverts", pwm_out, 1);
    wr(3'd5, 8'h02);
    chk("R6 pin released", pwm_oe, 0);
    chk("R6 output held low", pwm_out, 0);
  endtask

  task automatic t_collide;
    int c;
    logic [7:0] d;
    steps(12'hFFF - 12'hF81);
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'h0F);
    read_count(c);
    chk("R10 new preload waits for wrap", c, 12'hFFF);
    rd(3'd0, d);
    wr(3'd0, ctrl_v | 8'h08);
    tick_slow = 1'b1; rd_en = 1'b1; addr = 3'd0;
    #1 d = rdata;
    @(negedge clk);
    tick_slow = 1'b0; rd_en = 1'b0;
    chk("R8 colliding read shows old flag", d[4], 0);
    wr(3'd0, ctrl_v);
    rd(3'd0, d);
    chk("R8 wrap set beats read clear", d[4], 1);
    read_count(c);
    chk("R10 new reload value loaded", c, 12'hFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step_sources();
    t_wrap();
    t_duty();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule